// File: doc/BRIEF.md
# Seventh-Order Power-of-Two Noise Shaper

This block turns a signed PCM stream into a single-bit stream for a one-bit audio DAC. It advances once per pulse of a clock enable that runs at 256 times the audio sample rate. Between enables, an upstream interpolator holds or upsamples the input word. Inside is a chain of seven accumulators. The first stage integrates the difference between the input and the fed-back full-scale level. Each later stage takes a scaled copy of its predecessor, loses a small fraction of its own content, and is pulled back by a scaled copy of its successor. This cross-coupling is the leapfrog pattern. Every scaling is an arithmetic right shift, so the loop contains no multipliers.

The quantizer looks at the first accumulator plus shifted copies of the six later ones. It can also add a rectangular dither, drawn from a maximal-length shift register, whose span is a quarter of the feedback level each way. All state arithmetic wraps at the accumulator width and is never clipped. The usable input range is three quarters of full scale. Keeping the first stage free of leakage makes the long-run density of ones track the input exactly.

Top module: `sdm_leapfrog7`

## Requirements
- R1: A synchronous reset, active high, clears all seven accumulators and the output bit to zero and loads the dither register with 23'h2B5A5A; the first output after reset is 0.
- R2: While `ce_i` is low, the output bit, every accumulator and the dither register hold their values, whatever `pcm_i` and `dither_en_i` do.
- R3: On each enabled edge the first accumulator gains `pcm_i` (sign-extended) minus F, where F = +2^23 when the current output is 1 and -2^23 when it is 0; the sum wraps modulo 2^28 with no saturation.
- R4: On each enabled edge, accumulator k (k = 2..7) gains (acc[k-1] >>> 4) - (acc[k] >>> 4) - (acc[k+1] >>> 6), with acc[8] taken as 0, using floor shifts and arithmetic modulo 2^28.
- R5: On each enabled edge the output becomes 1 exactly when acc[1] + sum over k = 2..7 of (acc[k] >>> 4) + d is at least zero, with d the current dither value; all terms use the values before the edge.
- R6: The dither register is a 23-bit Fibonacci shift register that moves left, with new bit 0 = bit 22 XOR bit 17. When `dither_en_i` is high, d equals its low 22 bits read as unsigned minus 2^21, which gives a value in [-2^21, 2^21).
- R7: For a constant input u with |u| at most 0.75·2^23, the number of ones over N enabled cycles after reset lies within 16 of N·(2^23 + u)/2^24, with the dither either on or off.
- R8: With `dither_en_i` low, d is 0, but the dither register still advances on every enabled edge, so switching the dither on or off mid-stream resumes the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Modulator-rate clock enable |
| dither_en_i | input | 1 | Adds rectangular dither ahead of the quantizer |
| pcm_i | input | 24 | Signed PCM input sample |
| bit_o | output | 1 | Single-bit modulator output |

## Verification
The hardest property to show at the ports is the density guarantee. It only appears over thousands of cycles, and the higher stages leave a slowly drifting contribution on the quantizer. The stimulus therefore sweeps seven constant levels, from minus three quarters to plus three quarters of full scale. Each level runs once with dither and once without, starting fresh from reset each time. Every output bit is compared against an arithmetic model of the stage equations, and the ones are counted against the exact expected density. Separate passes stall the enable for long stretches and switch the dither on and off mid-stream. These passes show that the state is frozen during a stall and that the dither sequence keeps its phase.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int LFSR_W    = 23;
    localparam int LFSR_TAP  = 17;
    localparam int DEF_IN_W  = 24;
    localparam int DEF_ACC_W = 28;

    typedef enum logic {
        Q_LOW  = 1'b0,
        Q_HIGH = 1'b1
    } qbit_e;

    typedef logic [LFSR_W-1:0] lfsr_t;

    localparam lfsr_t DEF_SEED = 23'h2B5A5A;

    // one step of the maximal-length sequence, left shift
    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
    endfunction

endpackage

// File: rtl/sdm_dither.sv
module sdm_dither
    import sdm_pkg::*;
#(
    parameter int    IN_W  = DEF_IN_W,
    parameter int    ACC_W = DEF_ACC_W,
    parameter lfsr_t SEED  = DEF_SEED
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    ce_i,
    input  logic                    en_i,
    output logic signed [ACC_W-1:0] dith_o
);

    // dither spans a quarter of full scale each way
    localparam int DW = IN_W - 2;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (DW - 1);

    lfsr_t                   state_q;
    logic signed [ACC_W-1:0] raw;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEED;
        end else if (ce_i) begin
            state_q <= lfsr_next(state_q);
        end
    end

    assign raw    = $signed({{(ACC_W-DW){1'b0}}, state_q[DW-1:0]}) - HALF;
    assign dith_o = en_i ? raw : '0;

    a_r1_seed_load: assert property (@(posedge clk_i)
        rst_i |=> state_q == SEED)
        else $error("R1: dither register not reloaded");

    a_r8_advance: assert property (@(posedge clk_i) disable iff (rst_i)
        ce_i |=> state_q != $past(state_q))
        else $error("R8: dither register failed to advance");

    a_r2_dither_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(state_q))
        else $error("R2: dither register moved without enable");

    a_r6_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        ce_i |=> state_q != '0)
        else $error("R6: dither register locked at zero");

endmodule

// File: rtl/sdm_stage.sv
module sdm_stage #(
    parameter int ACC_W   = 28,
    parameter int GAIN_SH = 4,
    parameter int LEAK_SH = 4,
    parameter int RES_SH  = 6,
    parameter bit LEAKY   = 1'b1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    ce_i,
    input  logic signed [ACC_W-1:0] drive_i,
    input  logic signed [ACC_W-1:0] back_i,
    output logic signed [ACC_W-1:0] acc_o
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] leak;
    logic signed [ACC_W-1:0] nxt;

    generate
        if (LEAKY) begin : g_lossy
            assign leak = acc_q >>> LEAK_SH;
        end else begin : g_ideal
            assign leak = '0;
        end
    endgenerate

    // modulo arithmetic, no clipping
    assign nxt = acc_q + (drive_i >>> GAIN_SH) - leak - (back_i >>> RES_SH);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
        end else if (ce_i) begin
            acc_q <= nxt;
        end
    end

    assign acc_o = acc_q;

    a_r1_acc_clear: assert property (@(posedge clk_i)
        rst_i |=> acc_q == '0)
        else $error("R1: accumulator not cleared");

    a_r2_acc_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(acc_q))
        else $error("R2: accumulator moved without enable");

endmodule

// File: rtl/sdm_quant.sv
module sdm_quant
    import sdm_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int ORDER = 7,
    parameter int FF_SH = 4
) (
    input  logic signed [ACC_W-1:0] st_i [ORDER],
    input  logic signed [ACC_W-1:0] dith_i,
    output qbit_e                   dec_o
);

    localparam int SUM_W = ACC_W + $clog2(ORDER + 1) + 1;

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(st_i[0]) + SUM_W'(dith_i);
        for (int k = 1; k < ORDER; k++) begin
            sum = sum + SUM_W'(st_i[k] >>> FF_SH);
        end
        dec_o = sum[SUM_W-1] ? Q_LOW : Q_HIGH;
    end

endmodule

// File: rtl/sdm_leapfrog7.sv
module sdm_leapfrog7
    import sdm_pkg::*;
#(
    parameter int    IN_W    = DEF_IN_W,
    parameter int    ACC_W   = DEF_ACC_W,
    parameter int    ORDER   = 7,
    parameter int    GAIN_SH = 4,
    parameter int    LEAK_SH = 4,
    parameter int    RES_SH  = 6,
    parameter int    FF_SH   = 4,
    parameter lfsr_t SEED    = DEF_SEED
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   ce_i,
    input  logic                   dither_en_i,
    input  logic signed [IN_W-1:0] pcm_i,
    output logic                   bit_o
);

    localparam logic signed [ACC_W-1:0] FS = ACC_W'(1) << (IN_W - 1);

    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] err;
    logic signed [ACC_W-1:0] dith;
    logic signed [ACC_W-1:0] st    [ORDER];
    logic signed [ACC_W-1:0] drive [ORDER];
    logic signed [ACC_W-1:0] back  [ORDER];
    qbit_e                   dec;

    // exact negation of the feedback level, never an inversion
    assign fb  = bit_o ? FS : -FS;
    assign err = ACC_W'(pcm_i) - fb;

    for (genvar k = 0; k < ORDER; k++) begin : g_chain
        if (k == 0) begin : g_head
            assign drive[k] = err;
            assign back[k]  = '0;
        end else begin : g_body
            assign drive[k] = st[k-1];
            if (k == ORDER - 1) begin : g_tail
                assign back[k] = '0;
            end else begin : g_mid
                assign back[k] = st[k+1];
            end
        end

        sdm_stage #(
            .ACC_W  (ACC_W),
            .GAIN_SH((k == 0) ? 0 : GAIN_SH),
            .LEAK_SH(LEAK_SH),
            .RES_SH (RES_SH),
            .LEAKY  (k != 0)
        ) u_stage (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .ce_i   (ce_i),
            .drive_i(drive[k]),
            .back_i (back[k]),
            .acc_o  (st[k])
        );
    end

    sdm_dither #(
        .IN_W (IN_W),
        .ACC_W(ACC_W),
        .SEED (SEED)
    ) u_dither (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ce_i  (ce_i),
        .en_i  (dither_en_i),
        .dith_o(dith)
    );

    sdm_quant #(
        .ACC_W(ACC_W),
        .ORDER(ORDER),
        .FF_SH(FF_SH)
    ) u_quant (
        .st_i  (st),
        .dith_i(dith),
        .dec_o (dec)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bit_o <= 1'b0;
        end else if (ce_i) begin
            bit_o <= (dec == Q_HIGH);
        end
    end

    a_r1_out_clear: assert property (@(posedge clk_i)
        rst_i |=> !bit_o)
        else $error("R1: output not cleared");

    a_r2_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(bit_o))
        else $error("R2: output moved without enable");

endmodule

// File: tb/tb_sdm_leapfrog7.sv
module tb_sdm_leapfrog7;

    localparam longint FS   = 64'sd1 <<< 23;
    localparam int     NLEV = 2048;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ce  = 1'b0;
    logic               den = 1'b0;
    logic signed [23:0] pcm = '0;
    logic               bit_o;

    int tests = 0;
    int fails = 0;
    int ones  = 0;
    bit done  = 1'b0;

    // arithmetic model of the requirements
    longint      mx [7];
    int          my;
    logic [22:0] ml;

    always #10 clk = ~clk;

    sdm_leapfrog7 dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .ce_i       (ce),
        .dither_en_i(den),
        .pcm_i      (pcm),
        .bit_o      (bit_o)
    );

    function automatic longint wrap28(input longint v);
        longint t;
        t = v <<< 36;
        return t >>> 36;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 7; k++) mx[k] = 0;
        my = 0;
        ml = 23'h2B5A5A;  // R1 seed
    endtask

    task automatic model_step(input longint u, input bit d_on);
        longint q, d, fbv;
        longint nx [7];
        d   = d_on ? (longint'(ml[21:0]) - (64'sd1 <<< 21)) : 0;  // R6
        q   = mx[0] + d;                                           // R5
        for (int k = 1; k < 7; k++) q = q + (mx[k] >>> 4);
        fbv = (my != 0) ? FS : -FS;
        nx[0] = wrap28(mx[0] + u - fbv);                           // R3
        for (int k = 1; k < 7; k++) begin                          // R4
            nx[k] = wrap28(mx[k] + (mx[k-1] >>> 4) - (mx[k] >>> 4)
                           - ((k < 6) ? (mx[k+1] >>> 6) : 0));
        end
        for (int k = 0; k < 7; k++) mx[k] = nx[k];
        ml = {ml[21:0], ml[22] ^ ml[17]};                          // R8 advances always
        my = (q >= 0) ? 1 : 0;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; drives, waits one rising edge, compares
    task automatic run_cycle(input longint u, input bit c, input bit d_on, input string tag);
        pcm = u[23:0];
        ce  = c;
        den = d_on;
        @(negedge clk);
        if (c) model_step(u, d_on);
        check(bit_o == my[0], tag, longint'(bit_o), longint'(my));
        if (c && bit_o) ones++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ce  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ce  = 1'b0;
        model_reset();
        ones = 0;
        check(bit_o == 1'b0, "R1 output after reset", longint'(bit_o), 0);
    endtask

    function automatic longint tri_wave(input int t);
        int p, tv;
        p  = t % 1024;
        tv = (p < 512) ? p : 1023 - p;
        return longint'(tv - 256) * 24576;
    endfunction

    initial begin
        longint u, expv, diff;
        bit     held;

        // R1: state right after reset and the first outputs
        @(negedge clk);
        do_reset();
        for (int t = 0; t < 8; t++) run_cycle(0, 1'b1, 1'b0, "R1 first outputs");

        // R7 density plus R3 R4 R5 R6 bitwise agreement, seven levels
        for (int dsel = 0; dsel < 2; dsel++) begin
            for (int lv = -3; lv <= 3; lv++) begin
                do_reset();
                u = longint'(lv) * (FS / 4);
                for (int t = 0; t < NLEV; t++)
                    run_cycle(u, 1'b1, dsel[0],
                              dsel[0] ? "R3 R4 R5 R6 bitstream" : "R3 R4 R5 bitstream");
                expv = longint'(NLEV) * (4 + lv) / 8;
                diff = longint'(ones) - expv;
                if (diff < 0) diff = -diff;
                check(diff <= 16, "R7 ones density", longint'(ones), expv);
            end
        end

        // R2: sparse enable and a long stall with changing inputs
        do_reset();
        for (int t = 0; t < 800; t++)
            run_cycle(tri_wave(t * 4), (t % 4) == 0, 1'b1, "R2 sparse enable");
        held = bit_o;
        for (int t = 0; t < 40; t++) begin
            run_cycle(tri_wave(t * 97), 1'b0, t[0], "R2 stall");
            check(bit_o == held, "R2 output frozen", longint'(bit_o), longint'(held));
        end
        for (int t = 0; t < 300; t++)
            run_cycle(tri_wave(t * 3), 1'b1, 1'b1, "R2 resume");

        // R8: dither switched on and off mid-stream
        do_reset();
        for (int t = 0; t < 2000; t++)
            run_cycle(tri_wave(t), 1'b1, ((t / 64) % 2) == 1, "R8 dither toggling");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1 flow: actual=%0d expected=%0d cycles", 150000, 40000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule